// File: doc/BRIEF.md
# Framebuffer Display Scan-Out Controller

The block refreshes a fixed 640x480 true-colour panel from a framebuffer held in external memory. A two-register write/read port sets where the picture lives and how it is scanned. A raster counter produces the line and frame timing, and while scanning it issues one word read per visible pixel to a fixed-latency pixel memory. Each returned word is split into 8-bit red, green and blue outputs, which leave the block with data-enable and active-low syncs.

Every row of the framebuffer occupies 1024 words, and only the first 640 words of each row are fetched. The base address keeps only its upper 11 bits, so a picture always starts on a 2 MiB boundary. A rotate bit reverses the whole scan, which turns the picture by 180 degrees.

A two-state machine selects between `SCAN_OFF` and `SCAN_ON`. At the final clock of every frame the machine takes transition `ARM` (`SCAN_OFF` to `SCAN_ON`) when the enable bit is set, or transition `DISARM` (`SCAN_ON` to `SCAN_OFF`) when the enable bit is clear. In any other case it holds its state. The base and rotate settings are captured at the same clock, so a frame is never torn.

Top module: `fb_scanout`

## Requirements
- R1: After reset, both registers read zero, no read is issued, `pix_de` is low, both syncs are high and the colour outputs are zero.
- R2: A write at byte offset 0 stores the base address with bits 20:0 forced to zero. Reading offset 0 returns the stored value.
- R3: A write at byte offset 4 stores the control word: bit 0 is enable and bit 1 is rotate. Other bits read back as zero. Writes at any offset other than 0 and 4 change neither register.
- R4: A line is 800 clocks, with columns 0..639 visible and `hsync_n` low for columns 656..751. A frame is 525 lines, with lines 0..479 visible and `vsync_n` low for lines 490..491.
- R5: When scanning without rotation, every visible position (row, col) issues exactly one read, at byte address base + (row*1024 + col)*4.
- R6: When scanning with rotation, the read for (row, col) goes to byte address base + ((479-row)*1024 + (639-col))*4.
- R7: Read data is taken RD_LAT cycles after its request. The colour outputs, `pix_de` and both syncs appear RD_LAT+1 cycles after the raster position they belong to.
- R8: A returned word drives red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 have no effect.
- R9: In a frame scanned while disabled, no reads are issued, `pix_de` stays low and the colours stay zero, while both syncs keep running.
- R10: Enable, rotate and base are captured at the final clock of a frame and apply to the whole next frame. A write made during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 = base, 4 = control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_rd | output | 1 | Pixel word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Pixel word, valid RD_LAT cycles after its request |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |
| pix_de | output | 1 | Data enable for visible pixels |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench builds the block with a shrunken raster: an 8-pixel, 4-row visible area, a 15-clock line, an 8-line frame, a 16-word row stride and a read latency of 2. Each frame is then 120 clocks, so the bench can compare every clock of nine whole frames against an arithmetic model of position, address, sync and data. Those frames cover the disabled, plain, rotated, re-based and top-of-address cases, and the mid-frame writes whose effect must wait for the next frame.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [0:0] {
        SCAN_OFF = 1'b0,
        SCAN_ON  = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    localparam logic [2:0] OFS_BASE = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd4;
endpackage

// File: rtl/fbs_timing.sv
module fbs_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          active,
    output logic          hs_raw_n,
    output logic          vs_raw_n,
    output logic          frame_end
);
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] HS_START = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_STOP  = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_START = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_STOP  = VW'(V_ACTIVE + V_FP + V_SYNC);

    logic line_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    assign line_end  = (h_cnt == H_LAST);
    assign frame_end = line_end && (v_cnt == V_LAST);
    assign active    = (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE));
    assign hs_raw_n  = !((h_cnt >= HS_START) && (h_cnt < HS_STOP));
    assign vs_raw_n  = !((v_cnt >= VS_START) && (v_cnt < VS_STOP));

    // R4: the column count wraps to zero after the last clock of a line
    a_r4_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST) |=> (h_cnt == '0));

    // R4: a frame restarts at the top-left position
    a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (h_cnt == '0) && (v_cnt == '0));
endmodule

// File: rtl/fbs_regs.sv
module fbs_regs #(
    parameter int BASE_LSB = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [31:0] base_q,
    output logic        en_q,
    output logic        rot_q
);
    import fbs_pkg::*;

    localparam logic [31:0] BASE_MASK = ~((32'd1 << BASE_LSB) - 32'd1);

    logic wr_base, wr_ctrl;

    assign wr_base = reg_wr && (reg_addr == OFS_BASE);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            rot_q  <= 1'b0;
        end else begin
            if (wr_base) base_q <= reg_wdata & BASE_MASK;
            if (wr_ctrl) begin
                en_q  <= reg_wdata[0];
                rot_q <= reg_wdata[1];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_BASE: reg_rdata = base_q;
            OFS_CTRL: reg_rdata = {30'd0, rot_q, en_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R3: a control write is stored as written in its two low bits
    a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ({rot_q, en_q} == $past(reg_wdata[1:0])));

    // R3: writes at undefined offsets leave both registers unchanged
    a_r3_bad_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != OFS_BASE && reg_addr != OFS_CTRL)
        |=> $stable(base_q) && $stable(en_q) && $stable(rot_q));

    // R2: the kept upper bits of the base follow the written word
    a_r2_base_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> (base_q[31:BASE_LSB] == $past(reg_wdata[31:BASE_LSB])));
endmodule

// File: rtl/fbs_fetch.sv
module fbs_fetch #(
    parameter int H_ACTIVE        = 640,
    parameter int V_ACTIVE        = 480,
    parameter int HW              = 10,
    parameter int VW              = 10,
    parameter int ROW_STRIDE_LOG2 = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic          active,
    input  logic          frame_end,
    input  logic [31:0]   base_q,
    input  logic          en_q,
    input  logic          rot_q,
    output logic          mem_rd,
    output logic [31:0]   mem_addr
);
    import fbs_pkg::*;

    scan_state_e state, state_nx;
    logic [31:0] lat_base;
    logic        lat_rot;
    logic [31:0] col_off, row_off, pix_addr;

    // state register and frame-boundary capture of the settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SCAN_OFF;
            lat_base <= '0;
            lat_rot  <= 1'b0;
        end else begin
            state <= state_nx;
            if (frame_end) begin
                lat_base <= base_q;
                lat_rot  <= rot_q;
            end
        end
    end

    // transitions: ARM and DISARM, both only at the last clock of a frame
    always_comb begin
        state_nx = state;
        unique case (state)
            SCAN_OFF: if (frame_end && en_q)  state_nx = SCAN_ON;
            SCAN_ON:  if (frame_end && !en_q) state_nx = SCAN_OFF;
        endcase
    end

    // scan position to word offset, reversed in both axes when rotated
    always_comb begin
        col_off  = lat_rot ? 32'(H_ACTIVE - 1) - 32'(h_cnt) : 32'(h_cnt);
        row_off  = (lat_rot ? 32'(V_ACTIVE - 1) - 32'(v_cnt) : 32'(v_cnt))
                   << ROW_STRIDE_LOG2;
        pix_addr = lat_base + ((row_off + col_off) << 2);
    end

    // outputs per state
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        unique case (state)
            SCAN_OFF: ;
            SCAN_ON: begin
                mem_rd   = active;
                mem_addr = active ? pix_addr : '0;
            end
        endcase
    end

    // R9: a frame that starts with enable clear issues no reads at its start
    a_r9_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_end) && !$past(en_q)) |-> !mem_rd);

    // R10: captured settings do not move inside a frame
    a_r10_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(lat_base) && $stable(lat_rot));

    // R5: reads only happen inside the visible area
    a_r5_read_visible: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE)));
endmodule

// File: rtl/fbs_pixel.sv
module fbs_pixel #(
    parameter int RD_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        hs_raw_n,
    input  logic        vs_raw_n,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  pix_r,
    output logic [7:0]  pix_g,
    output logic [7:0]  pix_b,
    output logic        pix_de,
    output logic        hsync_n,
    output logic        vsync_n
);
    import fbs_pkg::*;

    // each stage carries {vsync_n, hsync_n, data-enable}
    localparam logic [2:0] IDLE_TAG = 3'b110;

    logic [2:0] pipe [RD_LAT];
    rgb_t       word_rgb;
    logic       unused_alpha;

    assign word_rgb     = rgb_t'(mem_rdata[23:0]);
    assign unused_alpha = ^mem_rdata[31:24];

    for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)      pipe[g] <= IDLE_TAG;
            else if (g == 0) pipe[g] <= {vs_raw_n, hs_raw_n, req};
            else             pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_de  <= 1'b0;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            {pix_r, pix_g, pix_b} <= '0;
        end else begin
            pix_de  <= pipe[RD_LAT-1][0];
            hsync_n <= pipe[RD_LAT-1][1];
            vsync_n <= pipe[RD_LAT-1][2];
            {pix_r, pix_g, pix_b} <= pipe[RD_LAT-1][0] ? word_rgb : '0;
        end
    end

    // R8: colours are black whenever no visible pixel is shown
    a_r8_black_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |-> ({pix_r, pix_g, pix_b} == '0));

    // R4: a visible pixel never coincides with a sync pulse
    a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        pix_de |-> (hsync_n && vsync_n));
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
    parameter int H_ACTIVE        = 640,
    parameter int H_FP            = 16,
    parameter int H_SYNC          = 96,
    parameter int H_BP            = 48,
    parameter int V_ACTIVE        = 480,
    parameter int V_FP            = 10,
    parameter int V_SYNC          = 2,
    parameter int V_BP            = 33,
    parameter int ROW_STRIDE_LOG2 = 10,
    parameter int RD_LAT          = 2,
    parameter int BASE_LSB        = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  pix_r,
    output logic [7:0]  pix_g,
    output logic [7:0]  pix_b,
    output logic        pix_de,
    output logic        hsync_n,
    output logic        vsync_n
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          active, hs_raw_n, vs_raw_n, frame_end;
    logic [31:0]   base_q;
    logic          en_q, rot_q;

    fbs_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .active(active), .hs_raw_n(hs_raw_n), .vs_raw_n(vs_raw_n),
        .frame_end(frame_end)
    );

    fbs_regs #(.BASE_LSB(BASE_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_q(base_q), .en_q(en_q), .rot_q(rot_q)
    );

    fbs_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .HW(HW), .VW(VW),
        .ROW_STRIDE_LOG2(ROW_STRIDE_LOG2)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .active(active), .frame_end(frame_end), .base_q(base_q),
        .en_q(en_q), .rot_q(rot_q), .mem_rd(mem_rd), .mem_addr(mem_addr)
    );

    fbs_pixel #(.RD_LAT(RD_LAT)) u_pixel (
        .clk(clk), .rst_n(rst_n), .req(mem_rd), .hs_raw_n(hs_raw_n),
        .vs_raw_n(vs_raw_n), .mem_rdata(mem_rdata),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_de(pix_de),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );
endmodule

// File: tb/fb_scanout_tb_top.sv
module fb_scanout_tb_top;
    localparam int HA = 8, HFP = 2, HS = 3, HBP = 2;
    localparam int VA = 4, VFP = 1, VS = 2, VBP = 1;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int FT = HT * VT;
    localparam int SLOG = 4;
    localparam int LAT = 2;
    localparam int NFRAMES = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic        pix_de, hsync_n, vsync_n;

    int vectors = 0;
    int misses  = 0;
    int c = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    // register model and per-frame settings model
    logic        m_en = 0, m_rot = 0, sc_en = 0, sc_rot = 0;
    logic [31:0] m_base = '0, sc_base = '0;

    logic        hist_rd [16];
    logic [31:0] hist_addr [16];
    logic        hist_hs [16];
    logic        hist_vs [16];
    logic [31:0] memq [LAT];

    always #10 clk = ~clk;

    fb_scanout #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
        .ROW_STRIDE_LOG2(SLOG), .RD_LAT(LAT), .BASE_LSB(21)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_r(pix_r),
        .pix_g(pix_g), .pix_b(pix_b), .pix_de(pix_de),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[7:0] ^ 8'hA5, a[9:2] ^ 8'h3C, a[9:2] + 8'd7, ~a[9:2]};
    endfunction

    // fixed-latency memory: garbage when nothing was requested
    always @(posedge clk) begin
        memq[0] <= mem_rd ? pat(mem_addr) : 32'hDEAD_BEEF;
        for (int i = 1; i < LAT; i++) memq[i] <= memq[i-1];
    end
    assign mem_rdata = memq[LAT-1];

    always @(posedge clk) if (run) c <= c + 1;

    // per-cycle comparison against the arithmetic raster model
    always @(negedge clk) begin
        if (run && !done) begin
            int pos, h, v, k, row, col;
            logic e_rd, e_hs, e_vs, o_de, o_hs, o_vs;
            logic [31:0] e_addr;
            logic [23:0] o_rgb;
            pos = c % FT; h = pos % HT; v = pos / HT;
            // R10: settings switch only at the first clock of a frame
            if (pos == 0 && c > 0) begin
                sc_en = m_en; sc_base = m_base; sc_rot = m_rot;
            end
            row = sc_rot ? (VA - 1 - v) : v;
            col = sc_rot ? (HA - 1 - h) : h;
            e_rd   = sc_en && (h < HA) && (v < VA);
            e_addr = sc_base + 32'((row * (1 << SLOG) + col) * 4);
            e_hs   = !((h >= HA + HFP) && (h < HA + HFP + HS));
            e_vs   = !((v >= VA + VFP) && (v < VA + VFP + VS));
            hist_rd[c % 16] = e_rd; hist_addr[c % 16] = e_addr;
            hist_hs[c % 16] = e_hs; hist_vs[c % 16] = e_vs;

            vectors++;
            if (mem_rd !== e_rd || (e_rd && mem_addr !== e_addr)) begin
                misses++;
                $display("FAIL %s cycle %0d: rd/addr actual %b/%h expected %b/%h",
                         !sc_en ? "R9" : (sc_rot ? "R6" : "R5"),
                         c, mem_rd, mem_addr, e_rd, e_addr);
            end

            if (c >= LAT + 1) begin
                k = (c - LAT - 1) % 16;
                o_de = hist_rd[k]; o_hs = hist_hs[k]; o_vs = hist_vs[k];
                o_rgb = o_de ? pat(hist_addr[k])[23:0] : 24'd0;
            end else begin
                o_de = 0; o_hs = 1; o_vs = 1; o_rgb = '0;
            end
            // R4 sync shape, delayed as per R7
            vectors++;
            if (hsync_n !== o_hs || vsync_n !== o_vs) begin
                misses++;
                $display("FAIL R4 cycle %0d: hs/vs actual %b/%b expected %b/%b",
                         c, hsync_n, vsync_n, o_hs, o_vs);
            end
            // R7 alignment, R8 unpacking, R9 blanking
            vectors++;
            if (pix_de !== o_de || {pix_r, pix_g, pix_b} !== o_rgb) begin
                misses++;
                $display("FAIL %s cycle %0d: de/rgb actual %b/%h expected %b/%h",
                         o_de ? "R7 R8" : "R9", c, pix_de,
                         {pix_r, pix_g, pix_b}, o_de, o_rgb);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd0) m_base = d & 32'hFFE0_0000;
        if (a == 3'd4) begin m_en = d[0]; m_rot = d[1]; end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        vectors++;
        if (reg_rdata !== e) begin
            misses++;
            $display("FAIL %s readback @%0d: actual %h expected %h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic wait_cycle(input int t);
        while (c < t) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (mem_rd !== 0 || pix_de !== 0 || hsync_n !== 1 || vsync_n !== 1 ||
            {pix_r, pix_g, pix_b} !== 24'd0) begin
            misses++;
            $display("FAIL R1 outputs: actual rd%b de%b hs%b vs%b rgb%h expected 0 0 1 1 0",
                     mem_rd, pix_de, hsync_n, vsync_n, {pix_r, pix_g, pix_b});
        end
        reg_addr = 3'd0; #1; vectors++;
        if (reg_rdata !== 0) begin misses++; $display("FAIL R1 base: actual %h expected 0", reg_rdata); end
        reg_addr = 3'd4; #1; vectors++;
        if (reg_rdata !== 0) begin misses++; $display("FAIL R1 ctrl: actual %h expected 0", reg_rdata); end

        @(posedge clk); #5;
        rst_n = 1'b1; run = 1'b1;

        // frame 0 disabled; register port checks (R2, R3)
        wait_cycle(20);
        wr(3'd0, 32'hABCD_1234);
        rd_chk(3'd0, 32'hABC0_0000, "R2");
        wr(3'd4, 32'hFFFF_FFFC);
        rd_chk(3'd4, 32'h0000_0000, "R3");
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0000_0003);
        rd_chk(3'd4, 32'h0000_0000, "R3");
        rd_chk(3'd0, 32'hABC0_0000, "R3");
        wr(3'd4, 32'h0000_0001);
        rd_chk(3'd4, 32'h0000_0001, "R3");
        // frame 1 plain scan; mid-frame rotate must wait (R10)
        wait_cycle(1 * FT + 40); wr(3'd4, 32'h3);
        // frame 2 rotated (R6); new base waits
        wait_cycle(2 * FT + 40); wr(3'd0, 32'h0020_0000);
        // frame 3 rotated at new base; disable for frame 4 (R9)
        wait_cycle(3 * FT + 40); wr(3'd4, 32'h0);
        // frame 4 off; top-of-range base, plain scan next
        wait_cycle(4 * FT + 40); wr(3'd0, 32'hFFFF_FFFF); wr(3'd4, 32'h1);
        rd_chk(3'd0, 32'hFFE0_0000, "R2");
        // frame 6: rotate with enable clear gives an idle frame 7
        wait_cycle(6 * FT + 40); wr(3'd4, 32'h2);
        wait_cycle(NFRAMES * FT);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(20 * 200000);
        misses++;
        $display("FAIL R1 watchdog: actual cycle %0d expected end by %0d", c, NFRAMES * FT);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule